// File: doc/BRIEF.md
# Trap and Interrupt Redirect Unit

This unit sits next to a processor's program-counter logic and turns trap and interrupt requests into a control-flow redirect. Two synchronous trap lines are accepted: one for an undefined instruction and one for an arithmetic overflow. There is also one asynchronous interrupt line. When a request is accepted, the unit does the following in a single clock edge:

- it latches a cause code;
- it copies the current PC into a dedicated saved-PC register, so no general-purpose link register is touched;
- it enters kernel mode and masks interrupts;
- it issues a one-cycle redirect to the handler.

A return command undoes the entry. It restores the mode that was in force before the trap, unmasks interrupts and redirects to the saved PC.

The handler target depends on the `vec_mode` pin. With `vec_mode` low, every cause goes to one fixed entry address. With `vec_mode` high, each cause gets its own 32-instruction slot at 0x80 plus the cause code shifted left by 7.

The redirect is a plain strobe with no ready and no back-pressure. The PC logic must accept it in the cycle it is high. All request inputs are sampled on the rising edge of `clk`. Every output is a register.

Top module: `exc_unit`

## Requirements
- R1: After reset, `kernel_mode`=1, `int_enable`=0, `cause`=0, `epc`=0 and `redirect_valid`=0. The hidden previous-mode shadow bit resets to user (0).
- R2: An undefined-instruction trap records cause code 0 (2-bit field).
- R3: An arithmetic-overflow trap records cause code 1. When both traps are requested in the same cycle, the undefined-instruction trap wins and the cause is 0.
- R4: On any accepted exception, `epc` takes the `pc_in` value of the request cycle. A return leaves `epc` unchanged.
- R5: On any accepted exception, `kernel_mode` becomes 1 and `int_enable` becomes 0. The mode that was in force before the exception is kept in a shadow bit.
- R6: With `vec_mode`=0, the exception target is 0x8000_0080 for every cause.
- R7: With `vec_mode`=1, the exception target is 0x80 + (cause << 7): 0x80 for undefined instruction, 0x100 for overflow and 0x180 for interrupt.
- R8: An interrupt request is taken only when `int_enable`=1 and no trap is requested, and it records cause code 2. Otherwise it has no effect: no redirect, and `cause`, `epc`, `kernel_mode` and `int_enable` are unchanged.
- R9: A return command (`eret`) with no exception accepted in the same cycle redirects to `epc`, restores `kernel_mode` from the shadow bit and sets `int_enable`=1, all on one edge.
- R10: `redirect_valid` is high for exactly the one cycle after an accepted exception or return, with `redirect_pc` valid in that cycle. It is low in every other cycle.
- R11: An exception accepted in the same cycle as `eret` takes priority, and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_mode | input | 1 | 1 selects the per-cause vector table, 0 selects the single fixed entry |
| trap_undef | input | 1 | Undefined-instruction trap request |
| trap_ovf | input | 1 | Arithmetic-overflow trap request |
| irq | input | 1 | External interrupt request, level |
| eret | input | 1 | Return-from-exception command |
| pc_in | input | 32 | PC of the instruction in the request cycle |
| redirect_valid | output | 1 | One-cycle redirect strobe |
| redirect_pc | output | 32 | Redirect target, valid with the strobe |
| cause | output | 2 | Latched cause code |
| epc | output | 32 | Saved exception PC |
| kernel_mode | output | 1 | 1 = kernel mode, 0 = user mode |
| int_enable | output | 1 | Interrupt enable |

## Verification
Every result of this unit appears exactly one clock edge after the request cycle, with nothing pending after that: the strobe, target, cause, saved PC, mode and enable. The bench therefore drives each request on a falling edge, lets one rising edge capture it and compares all outputs at the following falling edge. It then checks on one more falling edge that the strobe has dropped. The sweep covers every combination of the four request lines, with interrupts both masked and enabled and with both target modes. A directed sequence covers the return path from user and from kernel mode.

// File: rtl/exc_unit_pkg.sv
package exc_unit_pkg;
  localparam int CAUSE_W = 2;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_UNDEF = 2'd0,
    CAUSE_OVF   = 2'd1,
    CAUSE_IRQ   = 2'd2
  } cause_e;
endpackage

// File: rtl/exc_prio.sv
module exc_prio
  import exc_unit_pkg::*;
(
  input  logic               trap_undef,
  input  logic               trap_ovf,
  input  logic               irq,
  input  logic               ie,
  input  logic               eret,
  output logic               take_exc,
  output logic               take_ret,
  output logic [CAUSE_W-1:0] code
);
  logic any_trap;
  logic irq_ok;

  assign any_trap = trap_undef | trap_ovf;
  assign irq_ok   = irq & ie & ~any_trap;
  assign take_exc = any_trap | irq_ok;
  assign take_ret = eret & ~take_exc;

  always_comb begin
    if (trap_undef)    code = CAUSE_UNDEF;
    else if (trap_ovf) code = CAUSE_OVF;
    else               code = CAUSE_IRQ;
  end
endmodule

// File: rtl/exc_target.sv
module exc_target
  import exc_unit_pkg::*;
#(
  parameter int          PC_W       = 32,
  parameter logic [31:0] FIXED_ADDR = 32'h8000_0080,
  parameter logic [31:0] VEC_BASE   = 32'h0000_0080,
  parameter int          VEC_SHIFT  = 7
) (
  input  logic               vec_mode,
  input  logic [CAUSE_W-1:0] code,
  output logic [PC_W-1:0]    target
);
  localparam int PAD_W = PC_W - CAUSE_W;

  logic [PC_W-1:0] slot_off;
  logic [PC_W-1:0] vec_addr;

  assign slot_off = {{PAD_W{1'b0}}, code} << VEC_SHIFT;
  assign vec_addr = VEC_BASE[PC_W-1:0] + slot_off;
  assign target   = vec_mode ? vec_addr : FIXED_ADDR[PC_W-1:0];
endmodule

// File: rtl/exc_state.sv
module exc_state
  import exc_unit_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take_exc,
  input  logic               take_ret,
  input  logic [CAUSE_W-1:0] code,
  input  logic [PC_W-1:0]    pc_in,
  input  logic [PC_W-1:0]    exc_target,
  output logic               redir_q,
  output logic [PC_W-1:0]    redir_pc_q,
  output logic [CAUSE_W-1:0] cause_q,
  output logic [PC_W-1:0]    epc_q,
  output logic               kern_q,
  output logic               ie_q
);
  logic prev_kern_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_q     <= 1'b0;
      redir_pc_q  <= '0;
      cause_q     <= '0;
      epc_q       <= '0;
      kern_q      <= 1'b1;
      ie_q        <= 1'b0;
      prev_kern_q <= 1'b0;
    end else begin
      redir_q <= take_exc | take_ret;
      if (take_exc) begin
        redir_pc_q  <= exc_target;
        cause_q     <= code;
        epc_q       <= pc_in;
        prev_kern_q <= kern_q;
        kern_q      <= 1'b1;
        ie_q        <= 1'b0;
      end else if (take_ret) begin
        redir_pc_q <= epc_q;
        kern_q     <= prev_kern_q;
        ie_q       <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/exc_unit.sv
module exc_unit
  import exc_unit_pkg::*;
#(
  parameter int          PC_W       = 32,
  parameter logic [31:0] FIXED_ADDR = 32'h8000_0080,
  parameter logic [31:0] VEC_BASE   = 32'h0000_0080,
  parameter int          VEC_SHIFT  = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vec_mode,
  input  logic               trap_undef,
  input  logic               trap_ovf,
  input  logic               irq,
  input  logic               eret,
  input  logic [PC_W-1:0]    pc_in,
  output logic               redirect_valid,
  output logic [PC_W-1:0]    redirect_pc,
  output logic [CAUSE_W-1:0] cause,
  output logic [PC_W-1:0]    epc,
  output logic               kernel_mode,
  output logic               int_enable
);
  logic               take_exc;
  logic               take_ret;
  logic [CAUSE_W-1:0] code;
  logic [PC_W-1:0]    tgt;

  exc_prio prio_i (
    .trap_undef (trap_undef),
    .trap_ovf   (trap_ovf),
    .irq        (irq),
    .ie         (int_enable),
    .eret       (eret),
    .take_exc   (take_exc),
    .take_ret   (take_ret),
    .code       (code)
  );

  exc_target #(
    .PC_W       (PC_W),
    .FIXED_ADDR (FIXED_ADDR),
    .VEC_BASE   (VEC_BASE),
    .VEC_SHIFT  (VEC_SHIFT)
  ) tgt_i (
    .vec_mode (vec_mode),
    .code     (code),
    .target   (tgt)
  );

  exc_state #(.PC_W(PC_W)) st_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_exc   (take_exc),
    .take_ret   (take_ret),
    .code       (code),
    .pc_in      (pc_in),
    .exc_target (tgt),
    .redir_q    (redirect_valid),
    .redir_pc_q (redirect_pc),
    .cause_q    (cause),
    .epc_q      (epc),
    .kern_q     (kernel_mode),
    .ie_q       (int_enable)
  );
endmodule

// File: rtl/exc_unit_chk.sv
module exc_unit_chk
  import exc_unit_pkg::*;
#(
  parameter int          PC_W       = 32,
  parameter logic [31:0] FIXED_ADDR = 32'h8000_0080
) (
  input logic               clk,
  input logic               rst_n,
  input logic               vec_mode,
  input logic               trap_undef,
  input logic               trap_ovf,
  input logic               irq,
  input logic               eret,
  input logic [PC_W-1:0]    pc_in,
  input logic               redirect_valid,
  input logic [PC_W-1:0]    redirect_pc,
  input logic [CAUSE_W-1:0] cause,
  input logic [PC_W-1:0]    epc,
  input logic               kernel_mode,
  input logic               int_enable
);
  // R2
  undef_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_undef |=> (cause == 2'd0));

  // R3
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_ovf && !trap_undef) |=> (cause == 2'd1));

  // R4
  epc_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_undef || trap_ovf) |=> (epc == $past(pc_in)));

  // R5
  entry_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_undef || trap_ovf) |=> (kernel_mode && !int_enable && redirect_valid));

  // R6
  fixed_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((trap_undef || trap_ovf) && !vec_mode) |=> (redirect_pc == FIXED_ADDR[PC_W-1:0]));

  // R8
  masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !int_enable && !trap_undef && !trap_ovf && !eret) |=> !redirect_valid);

  // R9
  ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !trap_undef && !trap_ovf && !(irq && int_enable))
      |=> (int_enable && redirect_valid && redirect_pc == $past(epc)));

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_undef && !trap_ovf && !irq && !eret) |=> !redirect_valid);
endmodule

bind exc_unit exc_unit_chk #(.PC_W(PC_W), .FIXED_ADDR(FIXED_ADDR)) chk_i (
  .clk(clk), .rst_n(rst_n), .vec_mode(vec_mode), .trap_undef(trap_undef),
  .trap_ovf(trap_ovf), .irq(irq), .eret(eret), .pc_in(pc_in),
  .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .cause(cause),
  .epc(epc), .kernel_mode(kernel_mode), .int_enable(int_enable)
);

// File: tb/exc_unit_tb.sv
`timescale 1ns/1ps
module exc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vec_mode = 1'b0;
  logic        trap_undef = 1'b0, trap_ovf = 1'b0, irq = 1'b0, eret = 1'b0;
  logic [31:0] pc_in = '0;
  logic        redirect_valid;
  logic [31:0] redirect_pc;
  logic [1:0]  cause;
  logic [31:0] epc;
  logic        kernel_mode, int_enable;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  exc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .vec_mode(vec_mode), .trap_undef(trap_undef),
    .trap_ovf(trap_ovf), .irq(irq), .eret(eret), .pc_in(pc_in),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .cause(cause),
    .epc(epc), .kernel_mode(kernel_mode), .int_enable(int_enable)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic drive(logic u, logic o, logic i, logic r, logic [31:0] pc);
    trap_undef = u; trap_ovf = o; irq = i; eret = r; pc_in = pc;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0);
    step(); step();
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    // R1: reset state
    chk("R1 kernel", {31'd0, kernel_mode}, 32'd1);
    chk("R1 ie", {31'd0, int_enable}, 32'd0);
    chk("R1 cause", {30'd0, cause}, 32'd0);
    chk("R1 epc", epc, 32'd0);
    chk("R1 valid", {31'd0, redirect_valid}, 32'd0);

    // Sweep all request combinations x interrupt enable x target mode
    for (int vm = 0; vm < 2; vm++) begin
      for (int ien = 0; ien < 2; ien++) begin
        for (int c = 0; c < 16; c++) begin
          logic u, o, i, r;
          logic [31:0] p;
          logic ex;
          logic [1:0] code;
          logic [31:0] tgt;
          logic k0, ie0;
          u = c[0]; o = c[1]; i = c[2]; r = c[3];
          p = 32'h1000_0000 + 32'(c * 4 + ien * 256 + vm * 512);
          do_reset();
          vec_mode = vm[0];
          if (ien == 1) begin
            // return from reset state: shadow is user, so user mode with ie=1
            drive(0, 0, 0, 1, 0);
            step();
            drive(0, 0, 0, 0, 0);
            chk("R9 setup ie", {31'd0, int_enable}, 32'd1);
            chk("R9 setup mode", {31'd0, kernel_mode}, 32'd0);
            step();
          end
          k0 = (ien == 0);
          ie0 = (ien == 1);
          drive(u, o, i, r, p);
          step();
          drive(0, 0, 0, 0, 0);
          ex = u | o | (i & ie0);
          code = u ? 2'd0 : (o ? 2'd1 : 2'd2);
          tgt = vm[0] ? (32'h80 + (32'(code) << 7)) : 32'h8000_0080;
          if (ex) begin
            chk("R10 exc valid", {31'd0, redirect_valid}, 32'd1);
            chk(vm[0] ? "R7 vec target" : "R6 fixed target", redirect_pc, tgt);
            chk(u ? "R2 cause" : (o ? "R3 cause prio" : "R8 irq cause"), {30'd0, cause}, {30'd0, code});
            chk("R4 epc", epc, p);
            chk("R5 kernel", {31'd0, kernel_mode}, 32'd1);
            chk("R5 ie", {31'd0, int_enable}, 32'd0);
            if (r) chk("R11 exc over eret", redirect_pc, tgt);
          end else if (r) begin
            chk("R9 ret valid", {31'd0, redirect_valid}, 32'd1);
            chk("R9 ret target", redirect_pc, 32'd0);
            chk("R9 ret mode", {31'd0, kernel_mode}, 32'd0);
            chk("R9 ret ie", {31'd0, int_enable}, 32'd1);
            chk("R4 ret epc", epc, 32'd0);
          end else begin
            chk("R8 no redirect", {31'd0, redirect_valid}, 32'd0);
            chk("R8 cause kept", {30'd0, cause}, 32'd0);
            chk("R8 epc kept", epc, 32'd0);
            chk("R8 mode kept", {31'd0, kernel_mode}, {31'd0, k0});
            chk("R8 ie kept", {31'd0, int_enable}, {31'd0, ie0});
          end
          step();
          chk("R10 strobe drops", {31'd0, redirect_valid}, 32'd0);
        end
      end
    end

    // Return paths: user trap returns to user; kernel trap returns to kernel
    do_reset();
    vec_mode = 1'b0;
    drive(0, 0, 0, 1, 0); step();            // enter user, ie=1
    drive(0, 1, 0, 0, 32'h0000_4444); step(); // overflow from user
    drive(0, 0, 0, 0, 0);
    chk("R5 prev user entry", {31'd0, kernel_mode}, 32'd1);
    drive(0, 0, 0, 1, 0); step();
    drive(0, 0, 0, 0, 0);
    chk("R9 back to user", {31'd0, kernel_mode}, 32'd0);
    chk("R9 back to epc", redirect_pc, 32'h0000_4444);
    chk("R4 epc held on ret", epc, 32'h0000_4444);
    drive(1, 0, 0, 0, 32'h0000_5550); step(); // from user again
    drive(1, 0, 0, 0, 32'h0000_6660); step(); // nested, from kernel
    drive(0, 0, 0, 1, 0); step();
    drive(0, 0, 0, 0, 0);
    chk("R9 nested back to kernel", {31'd0, kernel_mode}, 32'd1);
    chk("R9 nested target", redirect_pc, 32'h0000_6660);
    drive(0, 0, 1, 0, 32'h0000_7770); step();  // ie now 1: irq taken
    drive(0, 0, 0, 0, 0);
    chk("R8 irq taken", {30'd0, cause}, 32'd2);
    chk("R6 irq fixed target", redirect_pc, 32'h8000_0080);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule